// File: doc/BRIEF.md
# Time-of-Day Periodic Waveform Generator

This block drives a single output pin from a nanosecond time base that lives outside it. The time base supplies the current sub-second nanosecond value together with a tick strobe. Each cycle that carries the strobe counts as one elapsed nanosecond. The block does not own the time base. It only watches it and counts.

Writes through a plain strobe-and-address port set four values: a first interval, a second interval, an enable (idle or clock) and a second-aligned flag. With the flag clear, the output is a free-running square wave: low for the first interval, then high for the second, repeating. With the flag set, the first interval becomes a phase offset into each second. The pin goes high on the tick where the nanosecond value equals that offset and stays high for the second interval. This gives one pulse per second.

The controller has six states:
- ST_IDLE: output off.
- ST_LOW and ST_HIGH: the two free-running phases.
- ST_WAIT: waiting for the phase match in second-aligned mode.
- ST_PULSE: the second-aligned pulse.
- ST_FAULT: the configuration was rejected.

The transitions are:
- Any state goes to ST_IDLE when the enable is cleared.
- ST_IDLE, ST_FAULT, and the end of ST_HIGH or ST_PULSE all lead to a start-of-low evaluation. That evaluation goes to ST_LOW, ST_WAIT or ST_FAULT.
- ST_LOW goes to ST_HIGH when its count expires.
- ST_WAIT goes to ST_PULSE on the phase match.

Top module: `tod_wavegen`

## Requirements
- R1: After reset the output and the error flag are low, the enable is idle, the first interval holds DEF_LOW (0) and the second interval holds DEF_HIGH (1000).
- R2: A write with `wr_en` high stores `wr_data` as follows: address 0 is the low interval or phase, address 1 is the high interval or pulse width, and address 2 is control, with bit 0 = enable clock and bit 1 = second-aligned. Address 3 is ignored.
- R3: In free-running mode the output stays low for exactly L ticks, then high for exactly H ticks, repeating. Cycles without `tod_tick` do not count, and the output changes only on edges where `tod_tick` is high.
- R4: In free-running mode the block enters fault when L or H is 6 or less, or above 0x3FFFFFFF. In fault, `cfg_err` is high and the output stays low.
- R5: In second-aligned mode the output rises on the tick edge where `tod_nsec` equals the phase. It stays high for the width in ticks and repeats once per second.
- R6: In second-aligned mode the block enters fault when the phase is NS_PER_SEC or more, when the width is 0, or when the width is NS_PER_SEC or more.
- R7: With the reset interval values and the second-aligned clock enabled, the block gives a 1000-tick pulse starting at nanosecond 0.
- R8: Clearing the enable forces the output low from the second clock edge after the write. The output then stays low and `cfg_err` is cleared.
- R9: Interval and mode writes made while running take effect only at the start of the next low interval. The interval in progress keeps its length, so no runt pulse is produced.
- R10: The fault state re-checks the configuration every cycle. A write that makes the configuration valid restarts the waveform, and `cfg_err` is low by the second edge after that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address |
| wr_data | input | IVL_W | Write data |
| tod_nsec | input | NS_W | Sub-second nanosecond field of the time of day |
| tod_tick | input | 1 | One-nanosecond advance strobe that accompanies `tod_nsec` |
| wave_out | output | 1 | Generated waveform |
| cfg_err | output | 1 | Configuration rejected; the output is held low |

## Verification
A wrong state or a wrong interval counter shows up at the pin within one interval. It appears as a high or low run whose length in ticks differs from the programmed value, or as a pulse edge at a nanosecond value other than the phase. Run lengths are therefore measured in ticks, with an irregular tick strobe, and the rising-edge time is recorded against `tod_nsec`. A configuration latched at the wrong moment shows in the first run that follows a mid-interval write. A fault decision that is wrong shows on `cfg_err` within two edges of the enabling write.

// File: rtl/wg_pkg.sv
package wg_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOW,
        ST_HIGH,
        ST_WAIT,
        ST_PULSE,
        ST_FAULT
    } wg_state_e;

    localparam logic [1:0] ADDR_LOW  = 2'd0;
    localparam logic [1:0] ADDR_HIGH = 2'd1;
    localparam logic [1:0] ADDR_CTRL = 2'd2;

    typedef struct packed {
        logic sync;
        logic clk_action;
    } wg_ctrl_t;

endpackage

// File: rtl/wg_regs.sv
module wg_regs
    import wg_pkg::*;
#(
    parameter int               IVL_W    = 32,
    parameter logic [IVL_W-1:0] DEF_LOW  = '0,
    parameter logic [IVL_W-1:0] DEF_HIGH = IVL_W'(1000)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [IVL_W-1:0] wr_data,
    output logic [IVL_W-1:0] low_ivl,
    output logic [IVL_W-1:0] high_ivl,
    output wg_ctrl_t         ctrl
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_ivl  <= DEF_LOW;
            high_ivl <= DEF_HIGH;
            ctrl     <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                ADDR_LOW:  low_ivl  <= wr_data;
                ADDR_HIGH: high_ivl <= wr_data;
                ADDR_CTRL: ctrl     <= wg_ctrl_t'(wr_data[1:0]);
                default:   ;
            endcase
        end
    end

    AST_CTRL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_CTRL) |=> (ctrl.clk_action == $past(wr_data[0]))); // R2

endmodule

// File: rtl/wg_limits.sv
module wg_limits
    import wg_pkg::*;
#(
    parameter int               IVL_W      = 32,
    parameter int               NS_PER_SEC = 1_000_000_000,
    parameter logic [IVL_W-1:0] MIN_IVL    = IVL_W'(6),
    parameter logic [IVL_W-1:0] MAX_IVL    = IVL_W'(32'h3FFF_FFFF)
) (
    input  logic [IVL_W-1:0] low_ivl,
    input  logic [IVL_W-1:0] high_ivl,
    input  wg_ctrl_t         ctrl,
    output logic             cfg_ok
);

    localparam logic [IVL_W-1:0] NS_LIM = IVL_W'(NS_PER_SEC);

    logic free_ok;
    logic sync_ok;

    always_comb begin
        free_ok = (low_ivl > MIN_IVL) && (low_ivl <= MAX_IVL) &&
                  (high_ivl > MIN_IVL) && (high_ivl <= MAX_IVL);
        sync_ok = (low_ivl < NS_LIM) && (high_ivl != '0) && (high_ivl < NS_LIM);
        cfg_ok  = ctrl.sync ? sync_ok : free_ok;
    end

endmodule

// File: rtl/wg_fsm.sv
module wg_fsm
    import wg_pkg::*;
#(
    parameter int               IVL_W   = 32,
    parameter int               NS_W    = 30,
    parameter logic [IVL_W-1:0] MIN_IVL = IVL_W'(6),
    parameter logic [IVL_W-1:0] MAX_IVL = IVL_W'(32'h3FFF_FFFF)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [NS_W-1:0]  tod_nsec,
    input  logic [IVL_W-1:0] cfg_low,
    input  logic [IVL_W-1:0] cfg_high,
    input  wg_ctrl_t         cfg_ctrl,
    input  logic             cfg_ok,
    output logic             wave_out,
    output logic             cfg_err
);

    localparam logic [IVL_W-1:0] ONE = IVL_W'(1);

    wg_state_e        st_q, st_d;
    logic             do_eval;
    logic [IVL_W-1:0] lo_q, hi_q, cnt_q;
    logic             sync_q;
    logic             cnt_done;
    logic             phase_hit;

    assign cnt_done  = tick && (cnt_q == '0);
    assign phase_hit = tick && ({{(IVL_W-NS_W){1'b0}}, tod_nsec} == lo_q);

    // next state
    always_comb begin
        st_d    = st_q;
        do_eval = 1'b0;
        if (!cfg_ctrl.clk_action) begin
            st_d = ST_IDLE;
        end else begin
            unique case (st_q)
                ST_IDLE, ST_FAULT: do_eval = 1'b1;
                ST_LOW:   if (cnt_done)  st_d = ST_HIGH;
                ST_HIGH:  if (cnt_done)  do_eval = 1'b1;
                ST_WAIT:  if (phase_hit) st_d = ST_PULSE;
                ST_PULSE: if (cnt_done)  do_eval = 1'b1;
                default:  st_d = ST_IDLE;
            endcase
            if (do_eval) begin
                if (!cfg_ok)            st_d = ST_FAULT;
                else if (cfg_ctrl.sync) st_d = ST_WAIT;
                else                    st_d = ST_LOW;
            end
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // active configuration and interval counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q   <= '0;
            hi_q   <= '0;
            sync_q <= 1'b0;
            cnt_q  <= '0;
        end else if (do_eval && cfg_ok) begin
            lo_q   <= cfg_low;
            hi_q   <= cfg_high;
            sync_q <= cfg_ctrl.sync;
            cnt_q  <= cfg_low - ONE;
        end else if ((st_q == ST_LOW && st_d == ST_HIGH) ||
                     (st_q == ST_WAIT && st_d == ST_PULSE)) begin
            cnt_q <= hi_q - ONE;
        end else if (tick && cnt_q != '0 &&
                     (st_q == ST_LOW || st_q == ST_HIGH || st_q == ST_PULSE)) begin
            cnt_q <= cnt_q - ONE;
        end
    end

    // outputs
    always_comb begin
        wave_out = (st_q == ST_HIGH) || (st_q == ST_PULSE);
        cfg_err  = (st_q == ST_FAULT);
    end

    AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_ctrl.clk_action |=> !wave_out); // R8

    AST_TICK_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(wave_out) && $past(cfg_ctrl.clk_action)) |-> $past(tick)); // R3

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_LOW) |-> (cnt_q < lo_q)); // R3

    AST_WIDTH_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_HIGH || st_q == ST_PULSE) |-> (cnt_q < hi_q)); // R5

    AST_ACTIVE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_LOW || st_q == ST_HIGH) |->
        (lo_q > MIN_IVL && lo_q <= MAX_IVL && hi_q > MIN_IVL && hi_q <= MAX_IVL)); // R4

    AST_PHASE_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(wave_out) && $past(sync_q)) |->
        ({{(IVL_W-NS_W){1'b0}}, $past(tod_nsec)} == $past(lo_q))); // R5

endmodule

// File: rtl/tod_wavegen.sv
module tod_wavegen
    import wg_pkg::*;
#(
    parameter int               IVL_W      = 32,
    parameter int               NS_PER_SEC = 1_000_000_000,
    parameter int               NS_W       = $clog2(NS_PER_SEC),
    parameter logic [IVL_W-1:0] MIN_IVL    = IVL_W'(6),
    parameter logic [IVL_W-1:0] MAX_IVL    = IVL_W'(32'h3FFF_FFFF),
    parameter logic [IVL_W-1:0] DEF_LOW    = '0,
    parameter logic [IVL_W-1:0] DEF_HIGH   = IVL_W'(1000)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [IVL_W-1:0] wr_data,
    input  logic [NS_W-1:0]  tod_nsec,
    input  logic             tod_tick,
    output logic             wave_out,
    output logic             cfg_err
);

    logic [IVL_W-1:0] low_ivl, high_ivl;
    wg_ctrl_t         ctrl;
    logic             cfg_ok;

    wg_regs #(
        .IVL_W   (IVL_W),
        .DEF_LOW (DEF_LOW),
        .DEF_HIGH(DEF_HIGH)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .low_ivl (low_ivl),
        .high_ivl(high_ivl),
        .ctrl    (ctrl)
    );

    wg_limits #(
        .IVL_W     (IVL_W),
        .NS_PER_SEC(NS_PER_SEC),
        .MIN_IVL   (MIN_IVL),
        .MAX_IVL   (MAX_IVL)
    ) u_limits (
        .low_ivl (low_ivl),
        .high_ivl(high_ivl),
        .ctrl    (ctrl),
        .cfg_ok  (cfg_ok)
    );

    wg_fsm #(
        .IVL_W  (IVL_W),
        .NS_W   (NS_W),
        .MIN_IVL(MIN_IVL),
        .MAX_IVL(MAX_IVL)
    ) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tod_tick),
        .tod_nsec(tod_nsec),
        .cfg_low (low_ivl),
        .cfg_high(high_ivl),
        .cfg_ctrl(ctrl),
        .cfg_ok  (cfg_ok),
        .wave_out(wave_out),
        .cfg_err (cfg_err)
    );

endmodule

// File: tb/sim_tod_wavegen.sv
module sim_tod_wavegen;

    localparam int CLK_PERIOD = 10;
    localparam int NS         = 2000;
    localparam int IVL_W      = 32;
    localparam int NS_W       = $clog2(NS);
    localparam int MAXV       = 32'h3FFF_FFFF;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             wr_en = 1'b0;
    logic [1:0]       wr_addr = '0;
    logic [IVL_W-1:0] wr_data = '0;
    logic [NS_W-1:0]  tod_nsec = '0;
    logic             tod_tick = 1'b0;
    logic             wave_out;
    logic             cfg_err;

    int errors = 0;
    int checks = 0;
    int tick_pct = 100;
    bit tod_run = 1'b0;
    int nsec_i = 0;

    int run_len = 0, done_len = 0, done_cnt = 0, rise_cnt = 0, rise_ns = -1;
    bit done_lvl = 1'b0, prev_out = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tod_wavegen #(.NS_PER_SEC(NS)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .tod_nsec(tod_nsec), .tod_tick(tod_tick),
        .wave_out(wave_out), .cfg_err(cfg_err)
    );

    // time-of-day model: one nanosecond per tick, wraps each second
    always @(negedge clk) begin
        if (tod_run && ($urandom_range(99) < tick_pct)) begin
            nsec_i = (nsec_i == NS - 1) ? 0 : nsec_i + 1;
            tod_nsec <= NS_W'(nsec_i);
            tod_tick <= 1'b1;
        end else begin
            tod_tick <= 1'b0;
        end
    end

    // run-length monitor, sampled just after each rising edge
    always @(posedge clk) begin
        #1;
        if (!rst_n) begin
            prev_out = 1'b0;
            run_len  = 0;
        end else if (wave_out !== prev_out) begin
            done_len = run_len + 1;
            done_lvl = prev_out;
            done_cnt++;
            if (wave_out) begin
                rise_ns = int'(tod_nsec);
                rise_cnt++;
            end
            run_len  = 0;
            prev_out = wave_out;
        end else if (tod_tick) begin
            run_len++;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = IVL_W'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_rise();
        int r = rise_cnt;
        while (rise_cnt == r) @(negedge clk);
    endtask

    task automatic next_run(output int len, output bit lvl);
        int c = done_cnt;
        while (done_cnt == c) @(negedge clk);
        len = done_len;
        lvl = done_lvl;
    endtask

    function automatic bit exp_fault(input bit sync, input longint lo, input longint hi);
        if (sync) return !(lo < NS && hi >= 1 && hi < NS);
        return !(lo > 6 && lo <= MAXV && hi > 6 && hi <= MAXV);
    endfunction

    task automatic go_idle();
        wr(2'd2, 0);
        @(negedge clk);
    endtask

    // start free-running, skip the first low, check n runs
    task automatic free_runs(input string req, input int lo, input int hi, input int n);
        int len; bit lvl;
        wr(2'd0, lo); wr(2'd1, hi); wr(2'd2, 1);
        wait_rise();
        for (int i = 0; i < n; i++) begin
            next_run(len, lvl);
            chk({req, " level"}, int'(lvl), (i % 2 == 0) ? 1 : 0);
            chk({req, " length"}, len, (i % 2 == 0) ? hi : lo);
        end
    endtask

    task automatic limit_case(input string req, input bit sync, input longint lo, input longint hi);
        int c;
        go_idle();
        wr(2'd0, int'(lo)); wr(2'd1, int'(hi)); wr(2'd2, sync ? 3 : 1);
        repeat (2) @(negedge clk);
        chk({req, " cfg_err"}, int'(cfg_err), int'(exp_fault(sync, lo, hi)));
        if (exp_fault(sync, lo, hi)) begin
            c = done_cnt;
            repeat (40) @(negedge clk);
            chk({req, " output held low"}, int'(wave_out) + (done_cnt - c), 0);
        end
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        int len; bit lvl; int c; int lo, hi;
        void'($urandom(32'd4242));
        repeat (4) @(negedge clk);
        chk("R1 wave_out in reset", int'(wave_out), 0);
        chk("R1 cfg_err in reset", int'(cfg_err), 0);
        rst_n = 1'b1; tod_run = 1'b1;
        repeat (5) @(negedge clk);
        chk("R1 wave_out idle after reset", int'(wave_out), 0);

        // R7: reset values, second-aligned
        tick_pct = 100;
        wr(2'd2, 3);
        wait_rise();
        chk("R7 default phase", rise_ns, 0);
        next_run(len, lvl);
        chk("R7 default width", len, 1000);

        // R3 directed with irregular ticks, then R2 unmapped address
        go_idle();
        tick_pct = 60;
        free_runs("R3 L7 H9", 7, 9, 4);
        wr(2'd3, 0);
        next_run(len, lvl);
        chk("R2 addr3 ignored high", len, 9);
        next_run(len, lvl);
        chk("R2 addr3 ignored low", len, 7);

        // R8: idle turns output off
        wait_rise();
        wr(2'd2, 0);
        @(negedge clk);
        chk("R8 low after idle", int'(wave_out), 0);
        c = done_cnt;
        repeat (60) @(negedge clk);
        chk("R8 no toggling while idle", done_cnt - c, 0);
        chk("R8 cfg_err low while idle", int'(cfg_err), 0);

        // R3 random intervals and tick densities
        for (int it = 0; it < 5; it++) begin
            go_idle();
            lo = $urandom_range(40, 7);
            hi = $urandom_range(40, 7);
            tick_pct = $urandom_range(100, 40);
            free_runs("R3 random", lo, hi, 4);
        end

        // R9: mid-interval writes wait for next low
        go_idle();
        tick_pct = 100;
        wr(2'd0, 12); wr(2'd1, 12); wr(2'd2, 1);
        wait_rise();
        wr(2'd0, 20); wr(2'd1, 25);
        next_run(len, lvl); chk("R9 current high kept", len, 12);
        next_run(len, lvl); chk("R9 new low", len, 20);
        next_run(len, lvl); chk("R9 new high", len, 25);

        // R4 free-running limits
        limit_case("R4 L=6", 1'b0, 6, 9);
        limit_case("R4 H=6", 1'b0, 9, 6);
        limit_case("R4 L=7 H=7", 1'b0, 7, 7);
        limit_case("R4 H=max", 1'b0, 7, MAXV);
        limit_case("R4 L=max+1", 1'b0, 64'h4000_0000, 9);

        // R10: recover from fault
        limit_case("R10 enter fault", 1'b0, 6, 9);
        wr(2'd0, 8);
        @(negedge clk);
        chk("R10 cfg_err cleared", int'(cfg_err), 0);
        wait_rise();
        next_run(len, lvl); chk("R10 high after recovery", len, 9);
        next_run(len, lvl); chk("R10 low after recovery", len, 8);

        // R6 second-aligned limits
        limit_case("R6 phase=NS", 1'b1, NS, 10);
        limit_case("R6 width=0", 1'b1, 5, 0);
        limit_case("R6 width=NS", 1'b1, 5, NS);
        limit_case("R6 phase=NS-1", 1'b1, NS - 1, 10);
        wait_rise();
        chk("R5 phase at last nanosecond", rise_ns, NS - 1);

        // R5 random phases and widths
        for (int it = 0; it < 3; it++) begin
            go_idle();
            lo = $urandom_range(NS - 1, 0);
            hi = $urandom_range(300, 1);
            tick_pct = $urandom_range(100, 50);
            wr(2'd0, lo); wr(2'd1, hi); wr(2'd2, 3);
            wait_rise();
            chk("R5 rise at phase", rise_ns, lo);
            next_run(len, lvl); chk("R5 pulse width", len, hi);
            next_run(len, lvl); chk("R5 gap to next second", len, NS - hi);
            chk("R5 next rise at phase", rise_ns, lo);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule